// File: doc/BRIEF.md
# SPI Register-Access Slave with Burst Transfers

This block lets an external microcontroller read and write a bank of 8-bit registers over a four-wire SPI link. The SPI pins run on their own clock and are brought into the system clock domain by the block. Inside the chip, the block drives a simple synchronous port that a register file sits on. That port carries an address, write data, a write strobe, a read strobe, and read data that returns one clock after the read strobe.

Every transaction opens with a command byte. Its top bit selects write (1) or read (0). The next bit enables address auto-increment. The low six bits name the starting register. Any number of data bytes may follow while the select line stays low, and raising select ends the burst at once.

The interface uses SPI mode 0 with the most significant bit first. MOSI is sampled on rising SCK and MISO changes on falling SCK. For the synchronised edges to be seen, SCK must stay high for at least four system clocks and low for at least four system clocks.

Top module: `spi_regbank_slave`

## Requirements
- R1: While select (`csn`) is high, `miso_oe` is 0, `miso` is 0, and no register strobe is started. While select is low, `miso_oe` is 1.
- R2: The first byte after select falls is a command byte. Command bit 7 = 1 makes every following data byte a write, and bit 7 = 0 makes them reads. `reg_we` and `reg_re` are never high in the same cycle.
- R3: Command bit 6 = 1 advances the address by one after each data byte. With bit 6 = 0, every data byte of the burst uses the same address.
- R4: Command bits 5:0 are the start address. Data bytes are 8 bits, sent and received most significant bit first in mode 0.
- R5: A burst may hold any number of data bytes. The auto-incremented address wraps from 63 to 0.
- R6: If select rises partway through a byte, that byte is discarded and causes no write. The next transaction begins again with a command byte.
- R7: Each received write data byte produces exactly one `reg_we` pulse, one system clock long. `reg_addr` holds steady during that pulse.
- R8: A read command issues one `reg_re` pulse, and each read data byte issues one more. The value captured from `reg_rdata` is shifted out starting with its top bit, beginning at the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the master |
| csn | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad |
| reg_addr | output | 6 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid one clock after `reg_re` |

## Verification
The bench uses the default parameters: a 6-bit address, 8-bit data and two synchroniser stages. With these values, a four-byte burst starting at address 62 reaches the wrap from 63 to 0. A 64-entry register model in the bench also sees the effect of every write and every read prefetch. The SCK half period is eight system clocks, so prefetched read data must be loaded well before the falling edge that starts the next byte, and the bench's check of the first bit exercises exactly that path.

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam int DIR_BIT = DATA_W - 1;
  localparam int INC_BIT = DATA_W - 2;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sck_sync, csn_sync, mosi_sync;
  logic sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync  <= '0;
      csn_sync  <= '1;
      mosi_sync <= '0;
      sck_prev  <= 1'b0;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck};
      csn_sync  <= {csn_sync[SYNC_STAGES-2:0], csn};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi};
      sck_prev  <= sck_sync[SYNC_STAGES-1];
    end
  end

  wire csn_s  = csn_sync[SYNC_STAGES-1];
  wire sck_s  = sck_sync[SYNC_STAGES-1];
  wire mosi_s = mosi_sync[SYNC_STAGES-1];
  wire sel    = ~csn_s;
  wire rise   = sel & sck_s & ~sck_prev;
  wire fall   = sel & ~sck_s & sck_prev;

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] rx_sr;
  logic [DATA_W-1:0] tx_sr, wdata_q;
  logic [ADDR_W-1:0] addr_q;
  logic in_cmd, wr_q, inc_q, we_q, re_q, load_pend, miso_q, oe_q;

  wire [DATA_W-1:0] rx_byte = {rx_sr, mosi_s};
  wire byte_done = rise && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      wdata_q   <= '0;
      addr_q    <= '0;
      in_cmd    <= 1'b1;
      wr_q      <= 1'b0;
      inc_q     <= 1'b0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      load_pend <= 1'b0;
      miso_q    <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      load_pend <= re_q;
      oe_q      <= sel;
      if (we_q && inc_q) addr_q <= addr_q + 1'b1;
      if (!sel) begin
        bit_cnt <= '0;
        in_cmd  <= 1'b1;
        miso_q  <= 1'b0;
        tx_sr   <= '0;
      end else begin
        if (rise) begin
          rx_sr   <= rx_byte[DATA_W-2:0];
          bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        end
        if (fall) begin
          miso_q <= tx_sr[DATA_W-1];
          tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
        end
        if (load_pend) tx_sr <= reg_rdata;
        if (byte_done) begin
          if (in_cmd) begin
            in_cmd <= 1'b0;
            wr_q   <= rx_byte[DIR_BIT];
            inc_q  <= rx_byte[INC_BIT];
            addr_q <= rx_byte[ADDR_W-1:0];
            re_q   <= ~rx_byte[DIR_BIT];
          end else if (wr_q) begin
            we_q    <= 1'b1;
            wdata_q <= rx_byte;
          end else begin
            re_q <= 1'b1;
            if (inc_q) addr_q <= addr_q + 1'b1;
          end
        end
      end
    end
  end

  assign miso      = miso_q;
  assign miso_oe   = oe_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;
endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn_s,
  input logic              miso,
  input logic              miso_oe,
  input logic              reg_we,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr
);
  // R7
  we_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  // R8
  re_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csn_s) |-> (!miso_oe && !miso));
  // R7
  we_addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $stable(reg_addr));
endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .miso(miso), .miso_oe(miso_oe),
  .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr));

// File: tb/spi_regbank_slave_bench.sv
module spi_regbank_slave_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, reg_we, reg_re;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  always #10 clk = ~clk;

  spi_regbank_slave u_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .sck(sck), .csn(csn), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
    .reg_rdata(reg_rdata));

  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int we_cnt = 0, re_cnt = 0, we_double = 0;
  logic we_prev = 1'b0;

  initial for (int i = 0; i < 64; i++) begin
    mem[i] = 8'(i * 7 + 3);
    exp_mem[i] = 8'(i * 7 + 3);
  end

  always @(posedge clk) begin
    if (reg_we) mem[reg_addr] <= reg_wdata;
    if (reg_re) reg_rdata <= mem[reg_addr];
    if (reg_we) we_cnt <= we_cnt + 1;
    if (reg_re) re_cnt <= re_cnt + 1;
    if (reg_we && we_prev) we_double <= we_double + 1;
    we_prev <= reg_we;
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r, input int nbits);
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = b[i];
      wait_clk(HALF);
      sck = 1'b1;
      r[i] = miso;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic spi_txn(input int n);
    logic [7:0] r;
    csn = 1'b0;
    wait_clk(HALF);
    for (int k = 0; k < n; k++) begin
      r = 8'h00;
      send_byte(txb[k], r, 8);
      rxb[k] = r;
    end
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(4 * HALF);
  endtask

  task automatic test_reset();
    chk(miso_oe == 1'b0, "R1 reset oe", int'(miso_oe), 0);
    chk(miso == 1'b0, "R1 reset miso", int'(miso), 0);
    chk(!reg_we && !reg_re, "R1 reset strobes", int'({reg_we, reg_re}), 0);
  endtask

  task automatic test_single();
    int w0;
    w0 = we_cnt;
    txb[0] = 8'h80 | 8'h15; txb[1] = 8'hA5;
    spi_txn(2);
    exp_mem[6'h15] = 8'hA5;
    chk(mem[6'h15] == 8'hA5, "R2 R4 single write", int'(mem[6'h15]), 8'hA5);
    chk(we_cnt - w0 == 1, "R7 one strobe per byte", we_cnt - w0, 1);
    txb[0] = 8'h15; txb[1] = 8'h00;
    spi_txn(2);
    chk(rxb[1] == 8'hA5, "R8 single read", int'(rxb[1]), 8'hA5);
    chk(rxb[0] == 8'h00, "R8 miso zero during command", int'(rxb[0]), 0);
  endtask

  task automatic test_burst_wrap();
    int r0, w0;
    logic [5:0] a;
    w0 = we_cnt;
    txb[0] = 8'hC0 | 8'h3E;
    txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33; txb[4] = 8'h44;
    spi_txn(5);
    a = 6'h3E;
    for (int k = 1; k <= 4; k++) begin
      exp_mem[a] = txb[k];
      chk(mem[a] == txb[k], "R5 R3 burst write wrap", int'(mem[a]), int'(txb[k]));
      a = a + 6'd1;
    end
    chk(we_cnt - w0 == 4, "R7 strobe count", we_cnt - w0, 4);
    r0 = re_cnt;
    txb[0] = 8'h40 | 8'h3E;
    for (int k = 1; k <= 4; k++) txb[k] = 8'h00;
    spi_txn(5);
    a = 6'h3E;
    for (int k = 1; k <= 4; k++) begin
      chk(rxb[k] == exp_mem[a], "R5 R8 burst read wrap", int'(rxb[k]), int'(exp_mem[a]));
      a = a + 6'd1;
    end
    chk(re_cnt - r0 == 5, "R8 read strobe count", re_cnt - r0, 5);
  endtask

  task automatic test_noinc();
    txb[0] = 8'h80 | 8'h10; txb[1] = 8'h5A; txb[2] = 8'h6B; txb[3] = 8'h7C;
    spi_txn(4);
    exp_mem[6'h10] = 8'h7C;
    chk(mem[6'h10] == 8'h7C, "R3 fixed address last value", int'(mem[6'h10]), 8'h7C);
    chk(mem[6'h11] == exp_mem[6'h11], "R3 neighbour untouched", int'(mem[6'h11]), int'(exp_mem[6'h11]));
    txb[0] = 8'h10; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    spi_txn(4);
    for (int k = 1; k <= 3; k++)
      chk(rxb[k] == 8'h7C, "R3 fixed address read", int'(rxb[k]), 8'h7C);
  endtask

  task automatic test_abort();
    int w0;
    logic [7:0] r;
    w0 = we_cnt;
    r = 8'h00;
    csn = 1'b0;
    wait_clk(HALF);
    send_byte(8'h80 | 8'h20, r, 8);
    send_byte(8'hFF, r, 4);
    wait_clk(HALF);
    csn = 1'b1;
    wait_clk(4 * HALF);
    chk(we_cnt == w0, "R6 no write on partial byte", we_cnt - w0, 0);
    chk(mem[6'h20] == exp_mem[6'h20], "R6 register unchanged", int'(mem[6'h20]), int'(exp_mem[6'h20]));
    txb[0] = 8'h20; txb[1] = 8'h00;
    spi_txn(2);
    chk(rxb[1] == exp_mem[6'h20], "R6 fresh command after abort", int'(rxb[1]), int'(exp_mem[6'h20]));
  endtask

  task automatic test_select_and_pulses();
    csn = 1'b0;
    wait_clk(HALF);
    chk(miso_oe == 1'b1, "R1 oe while selected", int'(miso_oe), 1);
    csn = 1'b1;
    wait_clk(HALF);
    chk(miso_oe == 1'b0 && miso == 1'b0, "R1 idle after deselect", int'({miso_oe, miso}), 0);
    chk(we_double == 0, "R7 strobe never two cycles", we_double, 0);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    test_reset();
    test_single();
    test_burst_wrap();
    test_noinc();
    test_abort();
    test_select_and_pulses();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule